// File: doc/BRIEF.md
# DES Round Function with Packed Substitution Table

This block evaluates the DES cipher function f for a single round. It takes a 32-bit right half and a 48-bit round subkey. The right half is expanded to 48 bits and mixed with the subkey by XOR. The result is split into eight 6-bit groups, each group is substituted to 4 bits, and the 32-bit word that comes out goes through the fixed DES permutation. Key scheduling, the half swap and the initial and final permutations belong to the surrounding cipher datapath, not to this block.

All eight substitution boxes live in one 256 x 8-bit table. Each byte of the table packs two neighbouring 4-bit entries of one box. The table has a single registered read port, so the eight boxes are looked up one after another over eight clocks. A small controller steps through three states. IDLE waits for `start`. On an accepted start (transition IDLE to FETCH) it captures the mixed 48-bit word. FETCH issues one table read per cycle for boxes 0 to 7. After the read for box 7 has been issued (transition FETCH to FINISH), FINISH merges the last nibble, permutes the word and writes the result, then returns unconditionally to IDLE (transition FINISH to IDLE).

The result stays on `f_out` with `valid` high until the next accepted start. This lets a round controller sample it at any later time.

Top module: `des_round_packed`

## Requirements
- R1: While `rst_n` is low and after its release, before any start, `valid` is 0 and `f_out` is 0.
- R2: The result equals the DES f function. DES bit 1 is `r_half[31]`. The expansion copies right-half bits in the standard overlapping pattern, and subkey bits [47:42] mix into box 0. Box k's 4-bit output lands in bits [31-4k -: 4] before the standard permutation.
- R3: For box b and a 6-bit group x, the entry index is n = row*16+col, with row = {x[5],x[0]} and col = x[4:1]. The table byte at address {b, n[5:1]} holds entry 2m in its high nibble and entry 2m+1 in its low nibble, where m = n[5:1]. The high nibble is used when n is even and the low nibble when n is odd, so address 0 holds 0xE4. An all-zero group selects high nibbles, and an all-one group selects the low nibble of the last byte of each box.
- R4: A start accepted in IDLE at clock edge T is followed by eight table reads in the next eight cycles. `f_out` takes the new result, and `valid` rises, at edge T+9.
- R5: `start` has no effect while a computation is under way. This includes the FINISH cycle.
- R6: `valid` drops at the edge after an accepted start and otherwise stays high once set. `f_out` changes only at the completion edge and holds its value in between.
- R7: `r_half` and `subkey` are sampled only at the accepted start edge. Changing them during the computation does not alter the result.
- R8: With right half 0xF0AAF0AA and subkey 0x1B02EFFC7072, the result is 0x234AA9BB.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation; taken only in IDLE |
| r_half | input | 32 | Right half of the round state |
| subkey | input | 48 | Round subkey |
| f_out | output | 32 | Round function result |
| valid | output | 1 | Result present; high from completion until the next accepted start |

## Verification
A wrong packing, a wrong nibble choice or a wrong table address corrupts exactly one 4-bit S-box output. The permutation spreads those four bits across the 32-bit result, and the corrupted value appears on `f_out` at the completion edge, nine cycles after the start. A miscounted box index or a lost accumulator nibble shows up in the same way, or it moves the rise of `valid` away from edge T+9. A controller that re-accepts start while busy drops `valid` early or changes `f_out` mid-run, and this is visible on the very next clock. All-zero and all-one inputs drive every box to the first high nibble and the last low nibble respectively, which isolates the nibble selection.

// File: rtl/des_rp_pkg.sv
package des_rp_pkg;

    localparam int HALF_W    = 32;
    localparam int SUB_W     = 48;
    localparam int N_BOX     = 8;
    localparam int BOX_IN    = 6;
    localparam int BOX_OUT   = 4;
    localparam int ENTRIES   = 64;
    localparam int ROM_AW    = 8;
    localparam int ROM_DW    = 2 * BOX_OUT;
    localparam int BOX_IDX_W = $clog2(N_BOX);
    localparam int PAIR_W    = ROM_AW - BOX_IDX_W;
    localparam int ACC_W     = (N_BOX - 1) * BOX_OUT;
    localparam int BOX_BITS  = ENTRIES * BOX_OUT;

    localparam logic [BOX_IDX_W-1:0] LAST_BOX = BOX_IDX_W'(N_BOX - 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_FINISH = 2'd2
    } rp_state_e;

    // Each box is a row-major string of 64 nibbles, where entry 0 is the
    // most significant nibble.
    localparam logic [BOX_BITS-1:0] SBOX_DATA [N_BOX] = '{
        256'hE4D12FB83A6C5907_0F74E2D1A6CB9538_41E8D62BFC973A50_FC8249175BE3A06D,
        256'hF18E6B34972DC05A_3D47F28EC01A69B5_0E7BA4D158C6932F_D8A13F42B67C05E9,
        256'hA09E63F51DC7B428_D709346A285ECBF1_D6498F30B12C5AE7_1AD069874FE3B52C,
        256'h7DE3069A1285BC4F_D8B56F03472C1AE9_A690CB7DF13E5284_3F06A1D8945BC72E,
        256'h2C417AB6853FD0E9_EB2C47D150FA3986_421BAD78F9C5630E_B8C71E2D6F09A453,
        256'hC1AF92680D34E75B_AF427C9561DE0B38_9EF528C3704A1DB6_432C95FABE17608D,
        256'h4B2EF08D3C975A61_D0B7491AE35C2F86_14BDC37EAF680592_6BD814A7950FE23C,
        256'hD2846FB1A93E50C7_1FD8A374C56B0E92_7B419CE206ADF358_21E74A8DFC90356B
    };

    // Output bit i (DES numbering, 1-based) takes input bit P_SRC[i-1].
    localparam int P_SRC [HALF_W] = '{
        16,  7, 20, 21, 29, 12, 28, 17,
         1, 15, 23, 26,  5, 18, 31, 10,
         2,  8, 24, 14, 32, 27,  3,  9,
        19, 13, 30,  6, 22, 11,  4, 25
    };

    // Packed table content: the byte at {box, pair} holds entries 2*pair
    // (high nibble) and 2*pair+1 (low nibble) of that box.
    function automatic logic [ROM_DW-1:0] packed_entry(input logic [ROM_AW-1:0] a);
        int box_i;
        int pair_i;
        box_i  = int'(a[ROM_AW-1 -: BOX_IDX_W]);
        pair_i = int'(a[PAIR_W-1:0]);
        return SBOX_DATA[box_i][BOX_BITS-1 - ROM_DW*pair_i -: ROM_DW];
    endfunction

endpackage

// File: rtl/des_rp_expand_mix.sv
module des_rp_expand_mix
    import des_rp_pkg::*;
(
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUB_W-1:0]  k_in,
    output logic [SUB_W-1:0]  mixed
);

    // Group j takes DES bits 4j .. 4j+5 of the half, wrapping 0 -> 32 and 33 -> 1.
    for (genvar j = 0; j < N_BOX; j++) begin : g_box
        for (genvar i = 0; i < BOX_IN; i++) begin : g_bit
            localparam int DES_POS = 4 * j + i;
            localparam int SRC     = (2 * HALF_W - DES_POS) % HALF_W;
            localparam int DST     = SUB_W - 1 - (BOX_IN * j + i);
            assign mixed[DST] = r_in[SRC] ^ k_in[DST];
        end
    end

endmodule

// File: rtl/des_rp_addr.sv
module des_rp_addr
    import des_rp_pkg::*;
(
    input  logic [BOX_IDX_W-1:0] box,
    input  logic [BOX_IN-1:0]    grp,
    output logic [ROM_AW-1:0]    addr,
    output logic                 lo_sel
);

    logic [BOX_IN-1:0] elem;

    always_comb begin
        // row from the outer bits, column from the inner four
        elem   = {grp[BOX_IN-1], grp[0], grp[BOX_IN-2:1]};
        addr   = {box, elem[BOX_IN-1:1]};
        lo_sel = elem[0];
    end

endmodule

// File: rtl/des_rp_rom.sv
module des_rp_rom
    import des_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rd_en,
    input  logic [ROM_AW-1:0] addr,
    output logic [ROM_DW-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rd_data <= packed_entry(addr);
        end
    end

endmodule

// File: rtl/des_rp_perm.sv
module des_rp_perm
    import des_rp_pkg::*;
(
    input  logic [HALF_W-1:0] s_in,
    output logic [HALF_W-1:0] p_out
);

    for (genvar i = 0; i < HALF_W; i++) begin : g_p
        localparam int SRC = HALF_W - P_SRC[i];
        assign p_out[HALF_W-1-i] = s_in[SRC];
    end

endmodule

// File: rtl/des_round_packed.sv
module des_round_packed
    import des_rp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] r_half,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out,
    output logic              valid
);

    rp_state_e              st;
    rp_state_e              st_nx;
    logic [SUB_W-1:0]       mixed_now;
    logic [SUB_W-1:0]       mixed_q;
    logic [BOX_IDX_W-1:0]   box_q;
    logic [BOX_IN-1:0]      grp_cur;
    logic [ROM_AW-1:0]      rom_addr;
    logic [ROM_DW-1:0]      rom_q;
    logic                   lo_sel;
    logic                   lo_q;
    logic                   rd_en;
    logic [BOX_OUT-1:0]     nib_cur;
    logic [ACC_W-1:0]       acc_q;
    logic [HALF_W-1:0]      s_word;
    logic [HALF_W-1:0]      p_word;

    des_rp_expand_mix u_mix (
        .r_in  (r_half),
        .k_in  (subkey),
        .mixed (mixed_now)
    );

    assign grp_cur = mixed_q[SUB_W-1 - BOX_IN*int'(box_q) -: BOX_IN];

    des_rp_addr u_addr (
        .box    (box_q),
        .grp    (grp_cur),
        .addr   (rom_addr),
        .lo_sel (lo_sel)
    );

    assign rd_en = (st == ST_FETCH);

    des_rp_rom u_rom (
        .clk     (clk),
        .rd_en   (rd_en),
        .addr    (rom_addr),
        .rd_data (rom_q)
    );

    assign nib_cur = lo_q ? rom_q[BOX_OUT-1:0] : rom_q[ROM_DW-1:BOX_OUT];
    assign s_word  = {acc_q, nib_cur};

    des_rp_perm u_perm (
        .s_in  (s_word),
        .p_out (p_word)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (start) st_nx = ST_FETCH;
            ST_FETCH:  if (box_q == LAST_BOX) st_nx = ST_FINISH;
            ST_FINISH: st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mixed_q <= '0;
            box_q   <= '0;
            lo_q    <= 1'b0;
            acc_q   <= '0;
            f_out   <= '0;
            valid   <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        mixed_q <= mixed_now;
                        box_q   <= '0;
                        valid   <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    lo_q  <= lo_sel;
                    box_q <= box_q + 1'b1;
                    if (box_q != '0) begin
                        acc_q <= {acc_q[ACC_W-BOX_OUT-1:0], nib_cur};
                    end
                end
                ST_FINISH: begin
                    f_out <= p_word;
                    valid <= 1'b1;
                end
                default: begin
                    valid <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/des_rp_chk.sv
module des_rp_chk
    import des_rp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              valid,
    input logic [HALF_W-1:0] f_out,
    input rp_state_e         st
);

    logic [3:0] since_q;
    logic [3:0] fetch_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q   <= '0;
            fetch_run <= '0;
        end else begin
            if (st == ST_IDLE && start) begin
                since_q <= 4'd1;
            end else if (since_q != 4'd0 && since_q != 4'd15) begin
                since_q <= since_q + 4'd1;
            end
            fetch_run <= (st == ST_FETCH) ? fetch_run + 4'd1 : 4'd0;
        end
    end

    // R4: valid rises exactly at edge T+9 after an accepted start
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid) |-> since_q == 4'd10);

    // R4: eight reads, one per box, before the finish cycle
    p_eight_reads_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FINISH) |-> fetch_run == 4'd8);

    // R5: a start during fetch does not return the controller to idle
    p_busy_ignore_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FETCH && start) |=> st != ST_IDLE);

    // R6: an accepted start clears valid
    p_start_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> !valid);

    // R6: valid holds unless a start is taken
    p_valid_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !(st == ST_IDLE && start)) |=> valid);

    // R6: result changes only at completion
    p_fout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_FINISH) |=> $stable(f_out));

endmodule

bind des_round_packed des_rp_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .valid (valid),
    .f_out (f_out),
    .st    (st)
);

// File: tb/tb_des_round_packed.sv
module tb_des_round_packed;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [31:0] r_half;
    logic [47:0] subkey;
    logic [31:0] f_out;
    logic        valid;

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    bit finished = 1'b0;

    des_round_packed dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .r_half (r_half),
        .subkey (subkey),
        .f_out  (f_out),
        .valid  (valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Standard tables, held as four 16-nibble rows per box.
    logic [63:0] SB_ROW [8][4] = '{
        '{64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175BE3A06D},
        '{64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9},
        '{64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C},
        '{64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E},
        '{64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453},
        '{64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D},
        '{64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C},
        '{64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B}
    };
    int E_TAB [48] = '{32, 1, 2, 3, 4, 5, 4, 5, 6, 7, 8, 9, 8, 9,10,11,
                       12,13,12,13,14,15,16,17,16,17,18,19,20,21,20,21,
                       22,23,24,25,24,25,26,27,28,29,28,29,30,31,32, 1};
    int P_TAB [32] = '{16, 7,20,21,29,12,28,17, 1,15,23,26, 5,18,31,10,
                        2, 8,24,14,32,27, 3, 9,19,13,30, 6,22,11, 4,25};

    function automatic logic [31:0] ref_f(input logic [31:0] r, input logic [47:0] k);
        logic [47:0] x;
        logic [31:0] s;
        logic [31:0] o;
        for (int i = 0; i < 48; i++) x[47-i] = r[32-E_TAB[i]] ^ k[47-i];
        for (int b = 0; b < 8; b++) begin
            logic [5:0] g;
            int row;
            int col;
            g   = x[47-6*b -: 6];
            row = {g[5], g[0]};
            col = int'(g[4:1]);
            s[31-4*b -: 4] = SB_ROW[b][row][63-4*col -: 4];
        end
        for (int i = 0; i < 32; i++) o[31-i] = s[32-P_TAB[i]];
        return o;
    endfunction

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // cycle model
    logic [31:0] m_f;
    logic        m_valid;
    logic [31:0] m_pend;
    int          m_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_f = '0; m_valid = 1'b0; m_cnt = 0; m_pend = '0;
        end else if (m_cnt == 0 && start) begin
            m_cnt = 9; m_valid = 1'b0; m_pend = ref_f(r_half, subkey);
        end else if (m_cnt != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_valid = 1'b1; m_f = m_pend;
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en && rst_n) begin
            chk1("R4 per-cycle valid", valid, m_valid);
            chk32("R6 per-cycle f_out", f_out, m_f);
        end
    end

    task automatic issue(input logic [31:0] r, input logic [47:0] k);
        @(posedge clk); #1;
        r_half = r; subkey = k; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic wait_valid(output int lat);
        lat = 0;
        do begin
            @(posedge clk); #1;
            lat++;
        end while (!valid && lat < 50);
    endtask

    task automatic run_vec(input logic [31:0] r, input logic [47:0] k, input string req);
        int lat;
        issue(r, k);
        wait_valid(lat);
        chk32("R4 latency", 32'(lat), 32'd9);
        chk32(req, f_out, ref_f(r, k));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R4 watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        logic [31:0] held;
        rst_n = 1'b0; start = 1'b0; r_half = '0; subkey = '0;
        repeat (3) @(posedge clk);
        #1;
        chk1("R1 reset valid", valid, 1'b0);
        chk32("R1 reset f_out", f_out, 32'h0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk1("R1 idle valid", valid, 1'b0);

        // R3: all-zero groups use high nibbles of byte 0 of each box
        run_vec(32'h0000_0000, 48'h0000_0000_0000, "R3 high nibbles");
        // R3: all-one groups use low nibble of the last byte of each box
        run_vec(32'h0000_0000, 48'hFFFF_FFFF_FFFF, "R3 low nibbles");
        // R8: published round vector
        run_vec(32'hF0AA_F0AA, 48'h1B02_EFFC_7072, "R8 known vector ref");
        chk32("R8 known vector", f_out, 32'h234A_A9BB);
        // R2: assorted patterns
        run_vec(32'h1234_5678, 48'h0123_4567_89AB, "R2 pattern a");
        run_vec(32'hFFFF_FFFF, 48'h0000_0000_0000, "R2 pattern b");
        run_vec(32'hA5A5_5A5A, 48'hFFFF_0000_FFFF, "R2 pattern c");
        run_vec(32'h8000_0001, 48'h8000_0000_0001, "R2 wrap bits");

        // R5: start mid-run with other data is ignored
        issue(32'hDEAD_BEEF, 48'hCAFE_F00D_1234);
        repeat (3) begin @(posedge clk); #1; end
        r_half = 32'h0F0F_0F0F; subkey = 48'h1111_2222_3333; start = 1'b1;
        repeat (2) begin @(posedge clk); #1; end
        start = 1'b0;
        wait_valid(lat);
        chk32("R5 busy start ignored", f_out, ref_f(32'hDEAD_BEEF, 48'hCAFE_F00D_1234));
        held = f_out;
        // R6: result and valid hold while idle
        repeat (12) begin @(posedge clk); #1; end
        chk1("R6 valid held", valid, 1'b1);
        chk32("R6 f_out held", f_out, held);

        // R7: inputs changed right after the accept edge
        issue(32'h3C3C_C3C3, 48'h5555_AAAA_5555);
        r_half = 32'hFFFF_0000; subkey = 48'h0000_FFFF_0000;
        chk1("R6 valid cleared by start", valid, 1'b0);
        chk32("R6 old f_out during run", f_out, held);
        wait_valid(lat);
        chk32("R7 sampled at start", f_out, ref_f(32'h3C3C_C3C3, 48'h5555_AAAA_5555));

        // R5/R6: start held high, ignored in finish, taken again in idle
        @(posedge clk); #1;
        r_half = 32'h7654_3210; subkey = 48'hFEDC_BA98_7654; start = 1'b1;
        @(posedge clk); #1;
        wait_valid(lat);
        chk32("R4 latency held start", 32'(lat), 32'd9);
        @(posedge clk); #1;
        chk1("R6 valid drops after restart", valid, 1'b0);
        wait_valid(lat);
        start = 1'b0;
        chk32("R5 second run latency", 32'(lat), 32'd9);
        chk32("R2 held start result", f_out, ref_f(32'h7654_3210, 48'hFEDC_BA98_7654));
        repeat (12) begin @(posedge clk); #1; end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule